// File: doc/BRIEF.md
# Floating-Point Operand Alignment Stage

This block prepares two single-precision operands for addition. Each operand arrives as a sign, an 8-bit biased exponent and a 24-bit mantissa with the hidden bit already made explicit. The block leaves the operand with the larger exponent as it is. It shifts the mantissa of the other operand right by the exponent difference, so that both operands leave the block on a common exponent.

Each output mantissa is widened by three low bits: guard, round and sticky. The sticky bit of the shifted operand records whether any bit that fell off the bottom of the widened word was a one. Rounding needs that information later. The complete variable shift and the sticky calculation are done in a single cycle. The sticky bit comes from an all-ones word shifted by the shift amount and inverted. That mask selects the discarded positions, which are then ANDed with the operand and OR-reduced.

A one-cycle register stage follows the logic, and a valid flag travels along with the data.

Top module: `fpalign_top`

## Requirements
- R1: `valid_o` equals `valid_i` from the previous clock edge, and reset clears it. Output fields are registered and update one cycle after an input with `valid_i` high.
- R2: `exp_o` is the larger of the two input exponents.
- R3: Both signs pass through unchanged. The operand whose exponent is not smaller leaves as its mantissa with three zero bits appended: `{mant, 3'b000}`.
- R4: Output mantissa layout: bits [26:3] hold the mantissa, bit 2 is guard, bit 1 is round and bit 0 is sticky. The operand with the strictly smaller exponent leaves as `{mant, 3'b000}` shifted right by the exponent difference d. Bit 0 of the result is then ORed with the sticky result.
- R5: The sticky result is 1 exactly when a one was present in the d discarded low positions of the widened word. A nonzero mantissa that is shifted never produces an all-zero output.
- R6: When d is 27 or more, the shift saturates. Bits [26:1] of the shifted operand are zero, and bit 0 is the OR of all 24 input mantissa bits.
- R7: When the exponents are equal, neither operand is shifted and both sticky bits are zero.
- R8: The block accepts a new operand pair in every cycle. Back-to-back inputs each produce their own correct result one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input operands are valid |
| a_sign_i | input | 1 | Sign of operand A |
| a_exp_i | input | 8 | Biased exponent of operand A |
| a_mant_i | input | 24 | Mantissa of operand A, hidden bit included |
| b_sign_i | input | 1 | Sign of operand B |
| b_exp_i | input | 8 | Biased exponent of operand B |
| b_mant_i | input | 24 | Mantissa of operand B, hidden bit included |
| valid_o | output | 1 | Output operands are valid |
| a_sign_o | output | 1 | Sign of operand A |
| b_sign_o | output | 1 | Sign of operand B |
| exp_o | output | 8 | Common exponent after alignment |
| a_mant_o | output | 27 | Aligned mantissa of A with guard, round and sticky |
| b_mant_o | output | 27 | Aligned mantissa of B with guard, round and sticky |

## Verification
In one cycle, the shift moves a data bit into position 0 while the mask logic ORs discarded bits into that same position. Both functions therefore decide the sticky bit together. The bench provokes this with differences of 3, 4 and 26, using mantissas whose set bits fall both on the boundary and below it. Saturation at differences of 27 and above is tested with zero and nonzero mantissas. Every result is judged against a bench model that shifts one bit at a time and accumulates each dropped bit, a method unrelated to the mask.

// File: rtl/fpalign_pkg.sv
package fpalign_pkg;

  // Number of extra low bits carried below the mantissa: guard, round, sticky.
  localparam int GRS_W = 3;

  // Which operand the alignment shifter acts on.
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_A    = 2'd1,
    SEL_B    = 2'd2
  } shift_sel_e;

endpackage

// File: rtl/fpalign_expcmp.sv
module fpalign_expcmp #(
  parameter int EXP_W = 8,
  parameter int LIMIT = 27,
  localparam int SH_W = $clog2(LIMIT + 1)
) (
  input  logic [EXP_W-1:0]       a_exp,
  input  logic [EXP_W-1:0]       b_exp,
  output logic [EXP_W-1:0]       exp_max,
  output fpalign_pkg::shift_sel_e sel,
  output logic [SH_W-1:0]        shamt,
  output logic                   sat
);
  import fpalign_pkg::*;

  logic             a_gt;
  logic             b_gt;
  logic [EXP_W-1:0] diff;

  // Magnitude of the exponent difference, both comparisons kept as named nets.
  function automatic logic [EXP_W-1:0] abs_diff(input logic [EXP_W-1:0] x,
                                                input logic [EXP_W-1:0] y);
    return (x >= y) ? (x - y) : (y - x);
  endfunction

  always_comb begin
    a_gt    = a_exp > b_exp;
    b_gt    = b_exp > a_exp;
    diff    = abs_diff(a_exp, b_exp);
    exp_max = a_gt ? a_exp : b_exp;
    if (a_gt)      sel = SEL_B;
    else if (b_gt) sel = SEL_A;
    else           sel = SEL_NONE;
    sat   = diff >= EXP_W'(LIMIT);
    shamt = sat ? SH_W'(LIMIT) : SH_W'(diff);
  end

endmodule

// File: rtl/fpalign_shift.sv
module fpalign_shift #(
  parameter int W    = 27,
  localparam int SH_W = $clog2(W + 1)
) (
  input  logic [W-1:0]    word,
  input  logic [SH_W-1:0] amt,
  output logic [W-1:0]    result,
  output logic            lost
);
  localparam logic [W-1:0] ONES = '1;

  logic [W-1:0] stg [SH_W+1];
  logic [W-1:0] keep_mask;
  logic [W-1:0] drop_mask;

  assign stg[0] = word;

  // Logarithmic barrel: stage k moves the word by 2**k when amt[k] is set.
  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    assign stg[k+1] = amt[k] ? (stg[k] >> (1 << k)) : stg[k];
  end

  // Shifted all-ones word, inverted, marks the positions that fall off.
  assign keep_mask = ONES << amt;
  assign drop_mask = ~keep_mask;
  assign lost      = |(word & drop_mask);

  assign result = {stg[SH_W][W-1:1], stg[SH_W][0] | lost};

endmodule

// File: rtl/fpalign_top.sv
module fpalign_top #(
  parameter int MANT_W = 24,
  parameter int EXP_W  = 8,
  localparam int EXT_W = MANT_W + fpalign_pkg::GRS_W,
  localparam int SH_W  = $clog2(EXT_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              a_sign_i,
  input  logic [EXP_W-1:0]  a_exp_i,
  input  logic [MANT_W-1:0] a_mant_i,
  input  logic              b_sign_i,
  input  logic [EXP_W-1:0]  b_exp_i,
  input  logic [MANT_W-1:0] b_mant_i,
  output logic              valid_o,
  output logic              a_sign_o,
  output logic              b_sign_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [EXT_W-1:0]  a_mant_o,
  output logic [EXT_W-1:0]  b_mant_o
);
  import fpalign_pkg::*;

  // Named internal events, also observed by the bound checker.
  shift_sel_e       sel_w;
  logic             sat_w;
  logic [SH_W-1:0]  shamt_w;
  logic [EXP_W-1:0] exp_max_w;

  logic [EXT_W-1:0] a_ext;
  logic [EXT_W-1:0] b_ext;
  logic [EXT_W-1:0] sh_in;
  logic [EXT_W-1:0] sh_out;
  logic             lost_w;
  logic [EXT_W-1:0] a_next;
  logic [EXT_W-1:0] b_next;

  function automatic logic [EXT_W-1:0] widen(input logic [MANT_W-1:0] m);
    return {m, {GRS_W{1'b0}}};
  endfunction

  fpalign_expcmp #(
    .EXP_W (EXP_W),
    .LIMIT (EXT_W)
  ) u_cmp (
    .a_exp   (a_exp_i),
    .b_exp   (b_exp_i),
    .exp_max (exp_max_w),
    .sel     (sel_w),
    .shamt   (shamt_w),
    .sat     (sat_w)
  );

  assign a_ext = widen(a_mant_i);
  assign b_ext = widen(b_mant_i);
  assign sh_in = (sel_w == SEL_A) ? a_ext : b_ext;

  fpalign_shift #(
    .W (EXT_W)
  ) u_shift (
    .word   (sh_in),
    .amt    (shamt_w),
    .result (sh_out),
    .lost   (lost_w)
  );

  assign a_next = (sel_w == SEL_A) ? sh_out : a_ext;
  assign b_next = (sel_w == SEL_B) ? sh_out : b_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sign_o <= 1'b0;
      b_sign_o <= 1'b0;
      exp_o    <= '0;
      a_mant_o <= '0;
      b_mant_o <= '0;
    end else if (valid_i) begin
      a_sign_o <= a_sign_i;
      b_sign_o <= b_sign_i;
      exp_o    <= exp_max_w;
      a_mant_o <= a_next;
      b_mant_o <= b_next;
    end
  end

endmodule

// File: rtl/fpalign_chk.sv
module fpalign_chk #(
  parameter int MANT_W = 24,
  parameter int EXP_W  = 8,
  localparam int EXT_W = MANT_W + fpalign_pkg::GRS_W
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    valid_i,
  input logic [EXP_W-1:0]        a_exp_i,
  input logic [EXP_W-1:0]        b_exp_i,
  input logic [MANT_W-1:0]       a_mant_i,
  input logic [MANT_W-1:0]       b_mant_i,
  input logic                    valid_o,
  input logic [EXP_W-1:0]        exp_o,
  input logic [EXT_W-1:0]        a_mant_o,
  input logic [EXT_W-1:0]        b_mant_o,
  input fpalign_pkg::shift_sel_e sel,
  input logic                    sat
);
  import fpalign_pkg::*;

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o);

  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !valid_o);

  a_r2_exp_max: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> (exp_o >= $past(a_exp_i)) && (exp_o >= $past(b_exp_i))
                && ((exp_o == $past(a_exp_i)) || (exp_o == $past(b_exp_i))));

  a_r3_a_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && a_exp_i >= b_exp_i) |=> a_mant_o == {$past(a_mant_i), {GRS_W{1'b0}}});

  a_r3_b_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && b_exp_i >= a_exp_i) |=> b_mant_o == {$past(b_mant_i), {GRS_W{1'b0}}});

  a_r5_a_not_erased: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && a_exp_i < b_exp_i && a_mant_i != '0) |=> a_mant_o != '0);

  a_r5_b_not_erased: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && b_exp_i < a_exp_i && b_mant_i != '0) |=> b_mant_o != '0);

  a_r6_a_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && sat && sel == SEL_A) |=> a_mant_o[EXT_W-1:1] == '0);

  a_r6_b_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && sat && sel == SEL_B) |=> b_mant_o[EXT_W-1:1] == '0);

  a_r7_tie_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && a_exp_i == b_exp_i) |-> (sel == SEL_NONE) && !sat);

endmodule

bind fpalign_top fpalign_chk #(
  .MANT_W (MANT_W),
  .EXP_W  (EXP_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .valid_i  (valid_i),
  .a_exp_i  (a_exp_i),
  .b_exp_i  (b_exp_i),
  .a_mant_i (a_mant_i),
  .b_mant_i (b_mant_i),
  .valid_o  (valid_o),
  .exp_o    (exp_o),
  .a_mant_o (a_mant_o),
  .b_mant_o (b_mant_o),
  .sel      (sel_w),
  .sat      (sat_w)
);

// File: tb/test_fpalign_top.sv
module test_fpalign_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic        a_sign_i = 1'b0, b_sign_i = 1'b0;
  logic [7:0]  a_exp_i = '0, b_exp_i = '0;
  logic [23:0] a_mant_i = '0, b_mant_i = '0;
  logic        valid_o, a_sign_o, b_sign_o;
  logic [7:0]  exp_o;
  logic [26:0] a_mant_o, b_mant_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fpalign_top i_fpalign_top (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
    .a_sign_i(a_sign_i), .a_exp_i(a_exp_i), .a_mant_i(a_mant_i),
    .b_sign_i(b_sign_i), .b_exp_i(b_exp_i), .b_mant_i(b_mant_i),
    .valid_o(valid_o), .a_sign_o(a_sign_o), .b_sign_o(b_sign_o),
    .exp_o(exp_o), .a_mant_o(a_mant_o), .b_mant_o(b_mant_o)
  );

  // Reference: move one bit per step and remember every bit that drops.
  function automatic logic [26:0] ref_align(input logic [23:0] m, input int d);
    logic [26:0] v = {m, 3'b000};
    logic        s = 1'b0;
    for (int i = 0; i < d; i++) begin
      s = s | v[0];
      v = v >> 1;
    end
    v[0] = v[0] | s;
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic sa, input logic [7:0] ea, input logic [23:0] ma,
                       input logic sb, input logic [7:0] eb, input logic [23:0] mb);
    valid_i = 1'b1;
    a_sign_i = sa; a_exp_i = ea; a_mant_i = ma;
    b_sign_i = sb; b_exp_i = eb; b_mant_i = mb;
  endtask

  task automatic expect_pair(input string req, input logic sa, input logic [7:0] ea,
                             input logic [23:0] ma, input logic sb, input logic [7:0] eb,
                             input logic [23:0] mb);
    int d = (ea > eb) ? int'(ea) - int'(eb) : int'(eb) - int'(ea);
    check({req, " valid"}, 32'(valid_o), 32'd1);
    check({req, " exp"}, 32'(exp_o), 32'((ea > eb) ? ea : eb));
    check({req, " sign a"}, 32'(a_sign_o), 32'(sa));
    check({req, " sign b"}, 32'(b_sign_o), 32'(sb));
    check({req, " mant a"}, 32'(a_mant_o), 32'(ref_align(ma, (ea < eb) ? d : 0)));
    check({req, " mant b"}, 32'(b_mant_o), 32'(ref_align(mb, (eb < ea) ? d : 0)));
  endtask

  task automatic one_pair(input string req, input logic sa, input logic [7:0] ea,
                          input logic [23:0] ma, input logic sb, input logic [7:0] eb,
                          input logic [23:0] mb);
    @(negedge clk);
    drive(sa, ea, ma, sb, eb, mb);
    @(negedge clk);
    valid_i = 1'b0;
    expect_pair(req, sa, ea, ma, sb, eb, mb);
  endtask

  task automatic t_reset;
    check("R1 reset valid", 32'(valid_o), 32'd0);
    check("R1 reset mant a", 32'(a_mant_o), 32'd0);
  endtask

  task automatic t_equal;  // R7 and R3
    one_pair("R7 tie", 1'b1, 8'd130, 24'hC00001, 1'b0, 8'd130, 24'hFFFFFF);
  endtask

  task automatic t_shift_b;  // R4: A larger, B moved
    one_pair("R4 d1", 1'b0, 8'd101, 24'h800000, 1'b1, 8'd100, 24'hFFFFFF);
    one_pair("R4 d3", 1'b0, 8'd90, 24'h8A0000, 1'b0, 8'd87, 24'h800007);
  endtask

  task automatic t_shift_a;  // R2, R4: B larger, A moved
    one_pair("R2 b larger", 1'b1, 8'd20, 24'hABCDEF, 1'b0, 8'd30, 24'h900000);
  endtask

  task automatic t_sticky;  // R5: bits fall below the sticky position
    one_pair("R5 d4 low one", 1'b0, 8'd50, 24'h800001, 1'b0, 8'd54, 24'h800000);
    one_pair("R5 d4 clean", 1'b0, 8'd50, 24'h800010, 1'b0, 8'd54, 24'h800000);
    one_pair("R5 d26", 1'b0, 8'd126, 24'hC00000, 1'b0, 8'd100, 24'h800001);
    check("R5 d26 sticky bit", 32'(b_mant_o[0]), 32'd1);
  endtask

  task automatic t_saturate;  // R6
    one_pair("R6 d27", 1'b0, 8'd127, 24'h800000, 1'b0, 8'd100, 24'h800000);
    check("R6 d27 result", 32'(b_mant_o), 32'd1);
    one_pair("R6 d200", 1'b0, 8'd10, 24'h000001, 1'b1, 8'd210, 24'hFFFFFF);
    check("R6 d200 result", 32'(a_mant_o), 32'd1);
    one_pair("R6 zero", 1'b0, 8'd250, 24'h800000, 1'b0, 8'd1, 24'h000000);
    check("R6 zero result", 32'(b_mant_o), 32'd0);
  endtask

  task automatic t_stream;  // R8: four pairs on consecutive cycles
    logic [7:0]  ea [4] = '{8'd40, 8'd10, 8'd77, 8'd5};
    logic [7:0]  eb [4] = '{8'd35, 8'd12, 8'd77, 8'd60};
    logic [23:0] ma [4] = '{24'hF0F0F1, 24'h812345, 24'hAAAAAA, 24'hFFFFFF};
    logic [23:0] mb [4] = '{24'h87654F, 24'hC00003, 24'h800000, 24'h800000};
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      drive(i[0], ea[i], ma[i], ~i[0], eb[i], mb[i]);
      @(negedge clk);
      expect_pair("R8 stream", i[0], ea[i], ma[i], ~i[0], eb[i], mb[i]);
    end
    valid_i = 1'b0;
    @(negedge clk);
    check("R1 idle after stream", 32'(valid_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_equal();
    t_shift_b();
    t_shift_a();
    t_sticky();
    t_saturate();
    t_stream();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule